// File: doc/BRIEF.md
# Signal Degrade Bit-Error-Rate Detector

This block decides whether a line is in a signal-degrade condition. It works from per-frame parity error counts. Each frame, a frame strobe delivers error counts from two parity sources, and a select input picks which one is used. Errors are summed over a monitoring block of N frames. Each finished block is classified, and the classified blocks are counted over an interval of M blocks.

While the state is clear, the block uses its "set" parameters. A block is bad when its error sum reaches the set error threshold. The state is declared as soon as the bad-block count in the current interval reaches the set block threshold. While the state is declared, the block uses its "clear" parameters. A block is good when its sum is below the clear error threshold. The state clears when the good-block count in the interval reaches the clear block threshold.

Two single-cycle inputs force the state to declared or to cleared. Every change of state raises a one-cycle change flag and an interrupt, and the interrupt can be masked.

Top module: `sd_ber_detector`

## Requirements
- R1: After synchronous reset, `sd_state`, `sd_delta` and `sd_irq` are all 0.
- R2: On a cycle with `frame_stb` high, the frame error count is taken from `err_a` when `src_sel` is 0 and from `err_b` when `src_sel` is 1.
- R3: While `sd_state` is 0, a block of `set_nfrm` frames is bad when its error sum is >= `set_lthr`. `sd_state` becomes 1 on the clock edge that ends the block where the interval's bad-block count reaches `set_mthr`, even if the interval has not ended.
- R4: The classified-block count restarts at 0 after every interval of `set_nblk` blocks (or `clr_nblk` when declared), so hits from separate intervals never combine.
- R5: While `sd_state` is 1, a block of `clr_nfrm` frames is good when its error sum is < `clr_lthr`. `sd_state` returns to 0 when the interval's good-block count reaches `clr_mthr`.
- R6: The per-block error sum saturates at 2^ACC_W-1 and never wraps to a small value.
- R7: A `force_set` pulse sets `sd_state` to 1 on the next edge, and a `force_clr` pulse sets it to 0. If both are high, `force_set` wins. Forcing overrides the algorithm in the same cycle.
- R8: Every change of state restarts the frame, block and interval counters, so partial progress under the old parameter set is discarded.
- R9: `sd_delta` is high for exactly the one cycle after each change of `sd_state`. `sd_irq` equals `sd_delta` when `irq_mask` is 0 and is 0 when `irq_mask` is 1.
- R10: A block length or interval length of 0 behaves as 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_stb | input | 1 | One cycle per frame, qualifies error inputs |
| src_sel | input | 1 | 0 selects err_a, 1 selects err_b |
| err_a | input | ERR_W | Frame error count, source A |
| err_b | input | ERR_W | Frame error count, source B |
| set_nfrm | input | FRM_W | Frames per block while clear |
| set_nblk | input | BLK_W | Blocks per interval while clear |
| set_lthr | input | THR_W | Bad-block error threshold |
| set_mthr | input | CNT_W | Bad blocks needed to declare |
| clr_nfrm | input | FRM_W | Frames per block while declared |
| clr_nblk | input | BLK_W | Blocks per interval while declared |
| clr_lthr | input | THR_W | Good-block error limit |
| clr_mthr | input | CNT_W | Good blocks needed to clear |
| force_set | input | 1 | One-shot force to declared |
| force_clr | input | 1 | One-shot force to cleared |
| irq_mask | input | 1 | 1 suppresses sd_irq |
| sd_state | output | 1 | Degrade state, 1 = declared |
| sd_delta | output | 1 | One-cycle change-of-state flag |
| sd_irq | output | 1 | Masked change-of-state interrupt |

## Verification
Internal state shows at the ports only through `sd_state`, so a wrong counter or classification appears as a declaration or clear on the wrong frame. The bench therefore checks the state right after the exact frame that should complete the threshold, and one frame before it. A stale window after a forced change, or a wrapped error sum, flips the state one block early or fails to flip it, so it is visible within one block of the faulty frame. Delta and interrupt faults appear in the single cycle after a change.

// File: rtl/sd_ber_pkg.sv
// Shared types for the signal degrade detector.
package sd_ber_pkg;
    typedef enum logic {
        SD_CLEAR = 1'b0,
        SD_DECL  = 1'b1
    } sd_mode_e;
endpackage

// File: rtl/sd_block_acc.sv
// Per-block error accumulator.
// Picks the error source, sums frame errors with saturation, and counts
// frames. blk_end pulses on the strobe that completes a block, and blk_errs
// then holds that block's full sum. Assumes nfrm is stable within a block.
// A length of 0 acts as 1.
module sd_block_acc #(
    parameter int ERR_W = 8,
    parameter int ACC_W = 8,
    parameter int FRM_W = 19
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             frame_stb,
    input  logic             src_sel,
    input  logic [ERR_W-1:0] err_a,
    input  logic [ERR_W-1:0] err_b,
    input  logic [FRM_W-1:0] nfrm,
    output logic             blk_end,
    output logic [ACC_W-1:0] blk_errs
);
    localparam int SUM_W = ((ACC_W > ERR_W) ? ACC_W : ERR_W) + 1;
    localparam logic [ACC_W-1:0] ACC_MAX = '1;

    logic [ACC_W-1:0] acc_q;
    logic [FRM_W-1:0] frm_q;
    logic [ERR_W-1:0] err_sel;
    logic [SUM_W-1:0] sum;
    logic [FRM_W-1:0] frm_lim;

    // Source select, saturating sum and end-of-block detect.
    always_comb begin
        err_sel  = src_sel ? err_b : err_a;
        sum      = SUM_W'(acc_q) + SUM_W'(err_sel);
        blk_errs = (sum > SUM_W'(ACC_MAX)) ? ACC_MAX : sum[ACC_W-1:0];
        frm_lim  = (nfrm == '0) ? FRM_W'(1) : nfrm;
        blk_end  = frame_stb && (({1'b0, frm_q} + 1'b1) >= {1'b0, frm_lim});
    end

    // Accumulator and frame counter, cleared at block end or restart.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            acc_q <= '0;
            frm_q <= '0;
        end else if (frame_stb) begin
            if (blk_end) begin
                acc_q <= '0;
                frm_q <= '0;
            end else begin
                acc_q <= blk_errs;
                frm_q <= frm_q + 1'b1;
            end
        end
    end

    // R6: inside a block the running sum never falls, so it cannot wrap.
    a_r6_acc_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_stb && !blk_end && !restart) |=> (acc_q >= $past(acc_q)));
endmodule

// File: rtl/sd_interval_ctr.sv
// Interval counter.
// Counts finished blocks and the blocks classified as hits within the current
// interval. thr_hit pulses on a block end whose hit count reaches mthr.
// Counters restart after nblk blocks or on restart. A length of 0 acts as 1.
module sd_interval_ctr #(
    parameter int BLK_W = 12,
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             blk_end,
    input  logic             blk_hit,
    input  logic [BLK_W-1:0] nblk,
    input  logic [CNT_W-1:0] mthr,
    output logic             thr_hit
);
    logic [BLK_W-1:0] blk_q;
    logic [CNT_W-1:0] hit_q;
    logic [CNT_W-1:0] hit_nx;
    logic [BLK_W-1:0] blk_lim;
    logic             int_end;

    // Saturating hit count, threshold compare and end-of-interval detect.
    always_comb begin
        hit_nx  = (blk_hit && hit_q != '1) ? hit_q + 1'b1 : hit_q;
        thr_hit = blk_end && (hit_nx >= mthr);
        blk_lim = (nblk == '0) ? BLK_W'(1) : nblk;
        int_end = ({1'b0, blk_q} + 1'b1) >= {1'b0, blk_lim};
    end

    // Block and hit counters, cleared at interval end or restart.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            blk_q <= '0;
            hit_q <= '0;
        end else if (blk_end) begin
            if (int_end) begin
                blk_q <= '0;
                hit_q <= '0;
            end else begin
                blk_q <= blk_q + 1'b1;
                hit_q <= hit_nx;
            end
        end
    end

    // R4: hits in an interval never exceed the blocks already counted in it.
    a_r4_hits_within_interval: assert property (@(posedge clk) disable iff (!rst_n)
        (32'(hit_q) <= 32'(blk_q)));
endmodule

// File: rtl/sd_ber_detector.sv
// Signal degrade detector, top level.
// Holds the degrade state and selects the set or clear parameters from it.
// Classifies each finished block as bad (while clear) or good (while declared).
// Applies forcing with force_set over force_clr, and restarts all windows on
// any state change. Assumes THR_W <= ACC_W and that forcing inputs are single
// cycle.
module sd_ber_detector
    import sd_ber_pkg::*;
#(
    parameter int ERR_W = 8,
    parameter int ACC_W = 8,
    parameter int FRM_W = 19,
    parameter int BLK_W = 12,
    parameter int THR_W = 4,
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_stb,
    input  logic             src_sel,
    input  logic [ERR_W-1:0] err_a,
    input  logic [ERR_W-1:0] err_b,
    input  logic [FRM_W-1:0] set_nfrm,
    input  logic [BLK_W-1:0] set_nblk,
    input  logic [THR_W-1:0] set_lthr,
    input  logic [CNT_W-1:0] set_mthr,
    input  logic [FRM_W-1:0] clr_nfrm,
    input  logic [BLK_W-1:0] clr_nblk,
    input  logic [THR_W-1:0] clr_lthr,
    input  logic [CNT_W-1:0] clr_mthr,
    input  logic             force_set,
    input  logic             force_clr,
    input  logic             irq_mask,
    output logic             sd_state,
    output logic             sd_delta,
    output logic             sd_irq
);
    sd_mode_e         mode_q, mode_nx;
    logic             delta_q;
    logic             change;
    logic [FRM_W-1:0] cur_nfrm;
    logic [BLK_W-1:0] cur_nblk;
    logic [CNT_W-1:0] cur_mthr;
    logic             blk_end;
    logic [ACC_W-1:0] blk_errs;
    logic             blk_hit;
    logic             thr_hit;

    // Active parameter set follows the current state.
    always_comb begin
        cur_nfrm = (mode_q == SD_DECL) ? clr_nfrm : set_nfrm;
        cur_nblk = (mode_q == SD_DECL) ? clr_nblk : set_nblk;
        cur_mthr = (mode_q == SD_DECL) ? clr_mthr : set_mthr;
        blk_hit  = (mode_q == SD_DECL) ? (blk_errs < ACC_W'(clr_lthr))
                                       : (blk_errs >= ACC_W'(set_lthr));
    end

    sd_block_acc #(
        .ERR_W(ERR_W), .ACC_W(ACC_W), .FRM_W(FRM_W)
    ) u_acc (
        .clk(clk), .rst_n(rst_n), .restart(change), .frame_stb(frame_stb),
        .src_sel(src_sel), .err_a(err_a), .err_b(err_b), .nfrm(cur_nfrm),
        .blk_end(blk_end), .blk_errs(blk_errs)
    );

    sd_interval_ctr #(
        .BLK_W(BLK_W), .CNT_W(CNT_W)
    ) u_int (
        .clk(clk), .rst_n(rst_n), .restart(change), .blk_end(blk_end),
        .blk_hit(blk_hit), .nblk(cur_nblk), .mthr(cur_mthr), .thr_hit(thr_hit)
    );

    // Next state: forcing first, then the algorithm's toggle.
    always_comb begin
        if (force_set)
            mode_nx = SD_DECL;
        else if (force_clr)
            mode_nx = SD_CLEAR;
        else if (thr_hit)
            mode_nx = (mode_q == SD_DECL) ? SD_CLEAR : SD_DECL;
        else
            mode_nx = mode_q;
        change = (mode_nx != mode_q);
    end

    // State register and one-cycle change flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q  <= SD_CLEAR;
            delta_q <= 1'b0;
        end else begin
            mode_q  <= mode_nx;
            delta_q <= change;
        end
    end

    assign sd_state = (mode_q == SD_DECL);
    assign sd_delta = delta_q;
    assign sd_irq   = delta_q & ~irq_mask;

    // R7: a set pulse always leaves the state declared.
    a_r7_force_set: assert property (@(posedge clk) disable iff (!rst_n)
        force_set |=> sd_state);
    // R7: a lone clear pulse always leaves the state clear.
    a_r7_force_clr: assert property (@(posedge clk) disable iff (!rst_n)
        (force_clr && !force_set) |=> !sd_state);
    // R9: the change flag only appears when the state actually moved.
    a_r9_delta_marks_change: assert property (@(posedge clk) disable iff (!rst_n)
        sd_delta |-> (sd_state != $past(sd_state)));
endmodule

// File: tb/sd_ber_detector_tb.sv
// Directed bench for sd_ber_detector. Inputs change on the falling edge, and
// outputs are sampled just before the next rising edge.
module sd_ber_detector_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frame_stb = 1'b0, src_sel = 1'b0;
    logic [7:0]  err_a = '0, err_b = '0;
    logic [18:0] set_nfrm = '0, clr_nfrm = '0;
    logic [11:0] set_nblk = '0, clr_nblk = '0;
    logic [3:0]  set_lthr = '0, clr_lthr = '0;
    logic [7:0]  set_mthr = '0, clr_mthr = '0;
    logic        force_set = 1'b0, force_clr = 1'b0, irq_mask = 1'b0;
    logic        sd_state, sd_delta, sd_irq;
    int          n_chk = 0, n_bad = 0;
    bit          done = 1'b0;

    always #2 clk = ~clk;

    sd_ber_detector u_dut (
        .clk(clk), .rst_n(rst_n), .frame_stb(frame_stb), .src_sel(src_sel),
        .err_a(err_a), .err_b(err_b),
        .set_nfrm(set_nfrm), .set_nblk(set_nblk), .set_lthr(set_lthr), .set_mthr(set_mthr),
        .clr_nfrm(clr_nfrm), .clr_nblk(clr_nblk), .clr_lthr(clr_lthr), .clr_mthr(clr_mthr),
        .force_set(force_set), .force_clr(force_clr), .irq_mask(irq_mask),
        .sd_state(sd_state), .sd_delta(sd_delta), .sd_irq(sd_irq)
    );

    task automatic check(input string tag, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %b expected %b", tag, act, exp);
        end
    endtask

    // One frame strobe. Returns on the next falling edge, after the update.
    task automatic frame(input logic [7:0] a, input logic [7:0] b);
        @(negedge clk);
        frame_stb = 1'b1; err_a = a; err_b = b;
        @(negedge clk);
        frame_stb = 1'b0; err_a = '0; err_b = '0;
    endtask

    task automatic force_pulse(input logic s, input logic c);
        @(negedge clk);
        force_set = s; force_clr = c;
        @(negedge clk);
        force_set = 1'b0; force_clr = 1'b0;
    endtask

    task automatic t_reset();
        check("R1 state", sd_state, 1'b0);
        check("R1 delta", sd_delta, 1'b0);
        check("R1 irq", sd_irq, 1'b0);
    endtask

    task automatic t_declare();
        set_nfrm = 2; set_nblk = 4; set_lthr = 5; set_mthr = 2;
        frame(3, 0); frame(3, 0);
        check("R3 one bad block", sd_state, 1'b0);
        frame(3, 0); frame(3, 0);
        check("R3 declare on second bad block", sd_state, 1'b1);
    endtask

    task automatic t_select();
        force_pulse(1'b0, 1'b1);
        src_sel = 1'b1;
        frame(9, 0); frame(9, 0); frame(9, 0); frame(9, 0);
        check("R2 src_sel=1 ignores err_a", sd_state, 1'b0);
        src_sel = 1'b0;
        frame(9, 0); frame(9, 0); frame(9, 0);
        check("R2 src_sel=0 one bad block", sd_state, 1'b0);
        frame(9, 0);
        check("R2 src_sel=0 uses err_a", sd_state, 1'b1);
    endtask

    task automatic t_clear();
        clr_nfrm = 1; clr_nblk = 3; clr_lthr = 2; clr_mthr = 2;
        frame(1, 0); frame(5, 0);
        check("R5 one good block", sd_state, 1'b1);
        frame(1, 0);
        check("R5 clear on second good block", sd_state, 1'b0);
    endtask

    task automatic t_interval();
        set_nfrm = 1; set_nblk = 2; set_lthr = 5; set_mthr = 2;
        frame(9, 0); frame(0, 0); frame(9, 0); frame(0, 0);
        check("R4 hits split across intervals", sd_state, 1'b0);
        frame(9, 0); frame(9, 0);
        check("R4 hits in one interval", sd_state, 1'b1);
    endtask

    task automatic t_saturate();
        clr_nfrm = 2; clr_nblk = 1; clr_lthr = 15; clr_mthr = 1;
        frame(128, 0); frame(128, 0);
        check("R6 saturated sum is not good", sd_state, 1'b1);
        frame(0, 0); frame(0, 0);
        check("R6 clean block clears", sd_state, 1'b0);
    endtask

    task automatic t_force_irq();
        irq_mask = 1'b0;
        @(negedge clk); force_set = 1'b1; force_clr = 1'b1;
        @(negedge clk); force_set = 1'b0; force_clr = 1'b0;
        check("R7 set wins over clear", sd_state, 1'b1);
        check("R9 delta after change", sd_delta, 1'b1);
        check("R9 irq unmasked", sd_irq, 1'b1);
        @(negedge clk);
        check("R9 delta one cycle", sd_delta, 1'b0);
        irq_mask = 1'b1;
        force_pulse(1'b0, 1'b1);
        check("R7 force clear", sd_state, 1'b0);
        check("R9 delta on clear", sd_delta, 1'b1);
        check("R9 irq masked", sd_irq, 1'b0);
        irq_mask = 1'b0;
        force_pulse(1'b0, 1'b1);
        check("R9 no delta without change", sd_delta, 1'b0);
    endtask

    task automatic t_restart();
        set_nfrm = 2; set_nblk = 4; set_lthr = 5; set_mthr = 2;
        frame(9, 0); frame(9, 0);
        force_pulse(1'b1, 1'b0);
        force_pulse(1'b0, 1'b1);
        frame(9, 0); frame(9, 0);
        check("R8 old hits discarded", sd_state, 1'b0);
        frame(9, 0); frame(9, 0);
        check("R8 fresh window declares", sd_state, 1'b1);
        force_pulse(1'b0, 1'b1);
    endtask

    task automatic t_zero_len();
        set_nfrm = 0; set_nblk = 0; set_lthr = 1; set_mthr = 1;
        frame(1, 0);
        check("R10 zero lengths act as one", sd_state, 1'b1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_declare();
        t_select();
        t_clear();
        t_interval();
        t_saturate();
        t_force_irq();
        t_restart();
        t_zero_len();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule